// File: doc/BRIEF.md
# Multi-mode configurable LUT cell

This block models one reconfigurable logic cell of a programmable fabric. A single 64-bit storage array is reused in one of five ways, chosen by a static mode code. It can be a 6-input truth table with one output, or a pair of 5-input truth tables that share their select inputs and drive two outputs. It can be a 64x1 memory with a synchronous write, a 32-stage shift register with an addressable tap, or two independent 16-stage shift registers with one tap each. In the split shift mode the last stage of the first chain is brought out, so outside wiring can feed it into the second chain.

Each of the two table outputs passes through an optional output flip-flop with a clock enable and a synchronous set/reset whose value is configurable. The mode, the initial array contents and the output-register options are captured while reset is asserted and stay fixed until the next reset. The select inputs always address the array combinationally; only writes, shifts and flip-flop captures wait for the rising clock edge.

Top module: `lutcell_multimode`

## Requirements
- R1: While `rst_n` is low, the array is loaded from `cfg_init`, the configuration inputs are captured, and each output flip-flop takes its bit of `cfg_oreg_val`; after reset a flip-flop that has not captured anything still shows that value on its `q_*` output.
- R2: Mode code 0, and the unused codes 5, 6 and 7, give the 6-input table: `out_a` is array bit `sel` (sel[5] picks the upper half), `out_b` and `casc_out` are 0, and `we` has no effect on the array.
- R3: Mode code 1 gives the dual table: `out_a` is array bit `sel[4:0]`, `out_b` is array bit 32+`sel[4:0]`, `casc_out` is 0, sel[5] has no effect and `we` has no effect on the array.
- R4: Mode code 2 gives a 64x1 memory: on a rising edge with `we` high, array bit `sel` takes `din`; `out_a` reads array bit `sel` combinationally; `out_b` and `casc_out` are 0.
- R5: Mode code 3 gives one 32-stage shift register in array bits 0..31: on a rising edge with `we` high, bit 0 takes `din` and each bit i (1..31) takes bit i-1; `out_a` is stage `sel[4:0]`, `casc_out` is stage 31, `out_b` is 0; bits 32..63 are untouched.
- R6: Mode code 4 gives two 16-stage shift registers: chain A in bits 0..15 fed by `din`, chain B in bits 16..31 fed by `din_b`, both shifting on a rising edge with `we` high; `out_a` is A stage `sel[3:0]`, `out_b` is B stage `sel[3:0]`, `casc_out` is A stage 15.
- R7: With `we` low, no mode changes the array.
- R8: When bit k of `cfg_oreg_use` (bit 0 for A, bit 1 for B) was 0 at reset, `q_a`/`q_b` equals the matching combinational output in the same cycle.
- R9: When the register is used, it captures the combinational output on a rising edge with `ff_ce` high and `ff_sr` low, and holds when `ff_ce` is low.
- R10: When the register is used, `ff_sr` high loads its bit of `cfg_oreg_val` on the next rising edge, regardless of `ff_ce`.
- R11: Changes on `cfg_mode`, `cfg_init`, `cfg_oreg_use` and `cfg_oreg_val` after reset has been released have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; configuration is captured while low |
| cfg_mode | input | 3 | Mode code (0 table6, 1 dual table5, 2 memory, 3 long shift, 4 split shift) |
| cfg_init | input | 64 | Initial array contents |
| cfg_oreg_use | input | 2 | Per output: 1 registers it, 0 passes it through |
| cfg_oreg_val | input | 2 | Per output: reset and set/reset value of the flip-flop |
| sel | input | 6 | Table select, memory address or shift tap |
| din | input | 1 | Write data, or shift input of the long chain and chain A |
| din_b | input | 1 | Shift input of chain B in split shift mode |
| we | input | 1 | Write / shift enable |
| ff_ce | input | 1 | Output flip-flop clock enable |
| ff_sr | input | 1 | Output flip-flop synchronous set/reset |
| out_a | output | 1 | Combinational output A |
| out_b | output | 1 | Combinational output B |
| q_a | output | 1 | Output A after its optional flip-flop |
| q_b | output | 1 | Output B after its optional flip-flop |
| casc_out | output | 1 | Last stage of the long chain or of chain A |

## Verification
A wrong array bit shows at `out_a` or `out_b` in the same cycle that `sel` addresses it, so the bench sweeps every select value in the table modes and reads back memory writes the cycle after the write edge. A misplaced shift shows one edge later at tap 0 and at `casc_out` after the chain length in edges, which the bench checks by reading every tap after a known pattern has been shifted in. A wrong output flip-flop state shows on `q_*` one edge after the capture, hold or set/reset cycle, and a leak of configuration changes after reset shows at once on the combinational outputs.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;

   typedef enum logic [2:0] {
      LC_TABLE6   = 3'd0,
      LC_DUAL5    = 3'd1,
      LC_MEMORY   = 3'd2,
      LC_SHIFT_L  = 3'd3,
      LC_SHIFT_2  = 3'd4
   } lc_mode_e;

   // Unused codes fall back to the 6-input table.
   function automatic lc_mode_e lc_decode(input logic [2:0] code);
      case (code)
         3'd1:    return LC_DUAL5;
         3'd2:    return LC_MEMORY;
         3'd3:    return LC_SHIFT_L;
         3'd4:    return LC_SHIFT_2;
         default: return LC_TABLE6;
      endcase
   endfunction

endpackage

// File: rtl/lutcell_store.sv
module lutcell_store
   import lutcell_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [(1<<ADDR_W)-1:0]  init_bits,
   input  lc_mode_e                mode,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    din,
   input  logic                    din_b,
   input  logic                    we,
   output logic [(1<<ADDR_W)-1:0]  bits
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int HALF  = DEPTH / 2;
   localparam int QTR   = DEPTH / 4;

   logic [DEPTH-1:0] arr_q;
   logic [DEPTH-1:0] arr_nxt;

   always_comb begin
      arr_nxt = arr_q;
      if (we) begin
         case (mode)
            LC_MEMORY: arr_nxt[addr] = din;
            LC_SHIFT_L: begin
               for (int i = 1; i < HALF; i++) arr_nxt[i] = arr_q[i-1];
               arr_nxt[0] = din;
            end
            LC_SHIFT_2: begin
               for (int i = 1; i < QTR; i++) begin
                  arr_nxt[i]     = arr_q[i-1];
                  arr_nxt[QTR+i] = arr_q[QTR+i-1];
               end
               arr_nxt[0]   = din;
               arr_nxt[QTR] = din_b;
            end
            default: arr_nxt = arr_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) arr_q <= init_bits;
      else        arr_q <= arr_nxt;
   end

   assign bits = arr_q;

endmodule

// File: rtl/lutcell_readmux.sv
module lutcell_readmux
   import lutcell_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic [(1<<ADDR_W)-1:0]  bits,
   input  lc_mode_e                mode,
   input  logic [ADDR_W-1:0]       sel,
   output logic                    rd_a,
   output logic                    rd_b,
   output logic                    rd_casc
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int HALF  = DEPTH / 2;
   localparam int QTR   = DEPTH / 4;

   logic [ADDR_W-1:0] idx_lo, idx_hi, idx_qa, idx_qb;

   assign idx_lo = {1'b0,  sel[ADDR_W-2:0]};
   assign idx_hi = {1'b1,  sel[ADDR_W-2:0]};
   assign idx_qa = {2'b00, sel[ADDR_W-3:0]};
   assign idx_qb = {2'b01, sel[ADDR_W-3:0]};

   always_comb begin
      rd_a    = 1'b0;
      rd_b    = 1'b0;
      rd_casc = 1'b0;
      case (mode)
         LC_DUAL5: begin
            rd_a = bits[idx_lo];
            rd_b = bits[idx_hi];
         end
         LC_SHIFT_L: begin
            rd_a    = bits[idx_lo];
            rd_casc = bits[HALF-1];
         end
         LC_SHIFT_2: begin
            rd_a    = bits[idx_qa];
            rd_b    = bits[idx_qb];
            rd_casc = bits[QTR-1];
         end
         default: rd_a = bits[sel];
      endcase
   end

endmodule

// File: rtl/lutcell_outreg.sv
module lutcell_outreg #(
   parameter bit BUILD_FF = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic use_ff,
   input  logic rst_val,
   input  logic sr_val,
   input  logic ce,
   input  logic sr,
   input  logic d,
   output logic q
);
   generate
      if (BUILD_FF) begin : g_ff
         logic q_r;
         always_ff @(posedge clk) begin
            if (!rst_n)  q_r <= rst_val;
            else if (sr) q_r <= sr_val;
            else if (ce) q_r <= d;
         end
         assign q = use_ff ? q_r : d;
      end else begin : g_wire
         logic unused_ok;
         assign unused_ok = &{clk, rst_n, use_ff, rst_val, sr_val, ce, sr};
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/lutcell_multimode.sv
module lutcell_multimode
   import lutcell_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter bit BUILD_FF = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [2:0]              cfg_mode,
   input  logic [(1<<ADDR_W)-1:0]  cfg_init,
   input  logic [1:0]              cfg_oreg_use,
   input  logic [1:0]              cfg_oreg_val,
   input  logic [ADDR_W-1:0]       sel,
   input  logic                    din,
   input  logic                    din_b,
   input  logic                    we,
   input  logic                    ff_ce,
   input  logic                    ff_sr,
   output logic                    out_a,
   output logic                    out_b,
   output logic                    q_a,
   output logic                    q_b,
   output logic                    casc_out
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int N_OUT = 2;

   generate
      if (ADDR_W < 3 || ADDR_W > 10) begin : g_bad_addr
         $error("lutcell_multimode: ADDR_W must lie in 3..10");
      end
   endgenerate

   lc_mode_e   mode_q;
   logic [1:0] oreg_use_q;
   logic [1:0] oreg_val_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q     <= lc_decode(cfg_mode);
         oreg_use_q <= cfg_oreg_use;
         oreg_val_q <= cfg_oreg_val;
      end
   end

   logic [DEPTH-1:0] arr_bits;

   lutcell_store #(.ADDR_W(ADDR_W)) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_bits (cfg_init),
      .mode      (mode_q),
      .addr      (sel),
      .din       (din),
      .din_b     (din_b),
      .we        (we),
      .bits      (arr_bits)
   );

   logic [N_OUT-1:0] comb_out;
   logic [N_OUT-1:0] reg_out;

   lutcell_readmux #(.ADDR_W(ADDR_W)) i_readmux (
      .bits    (arr_bits),
      .mode    (mode_q),
      .sel     (sel),
      .rd_a    (comb_out[0]),
      .rd_b    (comb_out[1]),
      .rd_casc (casc_out)
   );

   generate
      for (genvar k = 0; k < N_OUT; k++) begin : g_oreg
         lutcell_outreg #(.BUILD_FF(BUILD_FF)) i_outreg (
            .clk     (clk),
            .rst_n   (rst_n),
            .use_ff  (oreg_use_q[k]),
            .rst_val (cfg_oreg_val[k]),
            .sr_val  (oreg_val_q[k]),
            .ce      (ff_ce),
            .sr      (ff_sr),
            .d       (comb_out[k]),
            .q       (reg_out[k])
         );
      end
   endgenerate

   assign out_a = comb_out[0];
   assign out_b = comb_out[1];
   assign q_a   = reg_out[0];
   assign q_b   = reg_out[1];

endmodule

// File: rtl/lutcell_chk.sv
module lutcell_chk
   import lutcell_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input lc_mode_e          mode,
   input logic [1:0]        reg_use,
   input logic [1:0]        reg_val,
   input logic [ADDR_W-1:0] sel,
   input logic              din,
   input logic              din_b,
   input logic              we,
   input logic              ce,
   input logic              sr,
   input logic              out_a,
   input logic              out_b,
   input logic              q_a,
   input logic              q_b
);
   logic past_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   logic is_table;
   assign is_table = (mode == LC_TABLE6) || (mode == LC_DUAL5);

   // Table modes never change the array, even with we high.
   p_table_static_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && is_table && $stable(sel)) |-> ($stable(out_a) && $stable(out_b)));

   p_mem_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && mode == LC_MEMORY && we) |=> (!$stable(sel) || out_a == $past(din)));

   p_long_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && mode == LC_SHIFT_L && we && sel == '0) |=>
      (!$stable(sel) || out_a == $past(din)));

   p_split_heads_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && mode == LC_SHIFT_2 && we && sel == '0) |=>
      (!$stable(sel) || (out_a == $past(din) && out_b == $past(din_b))));

   p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(we) && $stable(sel)) |-> ($stable(out_a) && $stable(out_b)));

   p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !reg_use[0]) |-> (q_a == out_a));

   p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && reg_use[1] && ce && !sr) |=> (q_b == $past(out_b)));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && reg_use[0] && !ce && !sr) |=> $stable(q_a));

   p_setreset_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && reg_use[0] && sr) |=> (q_a == reg_val[0]));

endmodule

bind lutcell_multimode lutcell_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mode    (mode_q),
   .reg_use (oreg_use_q),
   .reg_val (oreg_val_q),
   .sel     (sel),
   .din     (din),
   .din_b   (din_b),
   .we      (we),
   .ce      (ff_ce),
   .sr      (ff_sr),
   .out_a   (out_a),
   .out_b   (out_b),
   .q_a     (q_a),
   .q_b     (q_b)
);

// File: tb/test_lutcell_multimode.sv
module test_lutcell_multimode;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_mode = '0;
   logic [63:0] cfg_init = '0;
   logic [1:0]  cfg_oreg_use = '0;
   logic [1:0]  cfg_oreg_val = '0;
   logic [5:0]  sel = '0;
   logic        din = 1'b0, din_b = 1'b0, we = 1'b0, ff_ce = 1'b0, ff_sr = 1'b0;
   logic        out_a, out_b, q_a, q_b, casc_out;

   always #(CLK_PERIOD/2) clk = ~clk;

   lutcell_multimode i_lutcell_multimode (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_init(cfg_init),
      .cfg_oreg_use(cfg_oreg_use), .cfg_oreg_val(cfg_oreg_val), .sel(sel),
      .din(din), .din_b(din_b), .we(we), .ff_ce(ff_ce), .ff_sr(ff_sr),
      .out_a(out_a), .out_b(out_b), .q_a(q_a), .q_b(q_b), .casc_out(casc_out)
   );

   // Scoreboard item: expected {out_a, out_b, q_a, q_b, casc_out}
   typedef struct {
      string      tag;
      logic [4:0] exp;
   } sb_item_t;
   sb_item_t sbq[$];

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   // Reference state
   int          m_mode;
   logic [63:0] m_arr;
   logic [1:0]  m_use, m_val, m_q;

   function automatic logic [2:0] ref_read(input logic [5:0] s);
      logic a, b, c;
      a = 1'b0; b = 1'b0; c = 1'b0;
      case (m_mode)
         1: begin a = m_arr[{1'b0, s[4:0]}]; b = m_arr[{1'b1, s[4:0]}]; end
         2: a = m_arr[s];
         3: begin a = m_arr[{1'b0, s[4:0]}]; c = m_arr[31]; end
         4: begin a = m_arr[{2'b00, s[3:0]}]; b = m_arr[{2'b01, s[3:0]}]; c = m_arr[15]; end
         default: a = m_arr[s];
      endcase
      return {a, b, c};
   endfunction

   task automatic do_reset(input logic [2:0] md, input logic [63:0] init,
                           input logic [1:0] use_ff, input logic [1:0] val);
      @(negedge clk);
      rst_n = 1'b0; cfg_mode = md; cfg_init = init;
      cfg_oreg_use = use_ff; cfg_oreg_val = val;
      we = 1'b0; ff_ce = 1'b0; ff_sr = 1'b0; sel = '0; din = 1'b0; din_b = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_mode = (md > 3'd4) ? 0 : int'(md);
      m_arr = init; m_use = use_ff; m_val = val; m_q = val;
   endtask

   // Drive one cycle, push the expectation, then advance the reference model.
   task automatic drive(input string tag, input logic [5:0] s, input logic d,
                        input logic db, input logic w, input logic ce, input logic sr);
      logic [2:0] rd;
      logic [1:0] comb, qexp;
      sb_item_t   it;
      @(negedge clk);
      sel = s; din = d; din_b = db; we = w; ff_ce = ce; ff_sr = sr;
      rd = ref_read(s);
      comb = {rd[1], rd[2]};
      for (int k = 0; k < 2; k++) qexp[k] = m_use[k] ? m_q[k] : comb[k];
      it.tag = tag;
      it.exp = {comb[0], comb[1], qexp[0], qexp[1], rd[0]};
      sbq.push_back(it);
      for (int k = 0; k < 2; k++) begin
         if (sr)      m_q[k] = m_val[k];
         else if (ce) m_q[k] = comb[k];
      end
      if (w) begin
         case (m_mode)
            2: m_arr[s] = d;
            3: begin
               for (int i = 31; i > 0; i--) m_arr[i] = m_arr[i-1];
               m_arr[0] = d;
            end
            4: begin
               for (int i = 15; i > 0; i--) begin
                  m_arr[i] = m_arr[i-1];
                  m_arr[16+i] = m_arr[16+i-1];
               end
               m_arr[0] = d; m_arr[16] = db;
            end
            default: ;
         endcase
      end
   endtask

   // Monitor
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_PERIOD/4);
         while (sbq.size() > 0) begin
            sb_item_t it;
            logic [4:0] act;
            it = sbq.pop_front();
            act = {out_a, out_b, q_a, q_b, casc_out};
            n_checks++;
            if (act !== it.exp) begin
               n_errors++;
               $display("FAIL %s: {out_a,out_b,q_a,q_b,casc} actual %b expected %b",
                        it.tag, act, it.exp);
            end
         end
      end
   end

   // Watchdog
   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] pat;
      pat = 64'hA5C3_0F1E_9B72_4D68;

      // R1 / R2: 6-input table, A registered with value 1, B bypassed
      do_reset(3'd0, pat, 2'b01, 2'b01);
      drive("R1", 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      cfg_mode = 3'd2; cfg_init = ~pat; cfg_oreg_use = 2'b10; cfg_oreg_val = 2'b00; // R11
      for (int s = 0; s < 64; s++) drive("R2", 6'(s), 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      for (int s = 0; s < 64; s += 7) drive("R11", 6'(s), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      drive("R9", 6'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      drive("R9", 6'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      drive("R9", 6'd7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      drive("R10", 6'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      drive("R10", 6'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      drive("R8", 6'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

      // R3: dual table, B registered, value 0
      do_reset(3'd1, 64'h0123_4567_89AB_CDEF, 2'b10, 2'b00);
      drive("R1", 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      for (int s = 0; s < 64; s++) drive("R3", 6'(s), 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
      drive("R10", 6'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      drive("R10", 6'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

      // R4: memory
      do_reset(3'd2, 64'h0, 2'b11, 2'b10);
      drive("R1", 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      for (int s = 0; s < 64; s++) drive("R4", 6'(s), s[0] ^ s[3], 1'b0, 1'b1, 1'b1, 1'b0);
      for (int s = 0; s < 64; s++) drive("R4", 6'(s), 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      for (int s = 0; s < 64; s += 5) drive("R7", 6'(s), ~s[0], 1'b0, 1'b0, 1'b0, 1'b0);
      for (int s = 0; s < 64; s++) drive("R7", 6'(s), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

      // R5: long shift chain
      do_reset(3'd3, 64'hFFFF_FFFF_0000_0000, 2'b00, 2'b00);
      for (int i = 0; i < 40; i++) drive("R5", 6'(i % 32), (i % 3) == 0, 1'b0, 1'b1, 1'b0, 1'b0);
      for (int s = 0; s < 32; s++) drive("R5", 6'(s), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      for (int s = 32; s < 64; s += 9) drive("R7", 6'(s), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

      // R6: split shift chains
      do_reset(3'd4, 64'h1234_5678_0000_FFFF, 2'b00, 2'b00);
      for (int i = 0; i < 20; i++) drive("R6", 6'(i % 16), i[0], i[1] ^ i[2], 1'b1, 1'b0, 1'b0);
      for (int s = 0; s < 16; s++) drive("R6", 6'(s), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

      // R2: undefined code behaves as 6-input table
      do_reset(3'd7, 64'hDEAD_BEEF_CAFE_F00D, 2'b00, 2'b00);
      for (int s = 0; s < 64; s += 3) drive("R2", 6'(s), 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);

      drive("R7", 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      @(negedge clk);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule